// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a simple request/acknowledge host port and an asynchronous 16-bit static RAM. The RAM has active-low chip enable, output enable, write enable and separate upper and lower byte enables. Each host access becomes a pin sequence whose phases last a whole number of controller clock cycles. Every phase length is worked out at elaboration from a nanosecond parameter and the clock period, rounded up. A phase whose timing is zero takes no cycles, and any non-zero timing takes at least one.

After reset a power-up counter keeps `pwr_ready` low and the controller idle until the supply-stable wait has elapsed. After that, a request is accepted only in the idle state. A read holds chip and output enable low until the slowest of the address, chip-enable, output-enable, byte-enable and read-cycle paths has been covered. The controller then samples the bus, masks out disabled lanes and returns the word with a one-cycle acknowledge. A write keeps output enable high throughout and frames the write as chip enable and write enable low together. Write enable rising ends the write. Data is driven during the pulse and any hold interval, and at no other time. Idle cycles are inserted before a write that follows a read, so the memory can release the bus first.

The state machine has eight states. POWERUP moves to IDLE once ready is high. IDLE goes to READ on a read request. On a write request it goes to TURN if the last access was a read, and to WPULSE otherwise. READ goes to ACK. TURN goes to WPULSE. WPULSE goes to WHOLD, WRECOV or ACK, taking the first of these whose length is non-zero. WHOLD goes to WRECOV or ACK. WRECOV goes to ACK, and ACK goes to IDLE. The phase lengths at the default 5 ns clock are: read 2 cycles, write pulse 2, hold 0, recovery 0, turnaround 1, power-up 20000.

Top module: `async_sram_ctrl`

## Requirements
- R1: `pwr_ready` is low until exactly PWR_CYC rising edges have passed with reset released, and high from then on. Before that, chip enable stays high, no acknowledge is given and requests are ignored.
- R2: During reset every memory strobe (chip, output, write, upper and lower byte enable) is high, `host_ack` is low and `pwr_ready` is low.
- R3: A read drives chip and output enable low and write enable high for RD_CYC cycles. RD_CYC is the largest rounded value among the read-cycle, address-access, chip-enable-access, output-enable-access and byte-enable-access timings. The first of these cycles follows the accepting edge. Byte-enable pins are low for the lanes selected by `host_be`, where bit 0 selects data [7:0] and the lower pin, and bit 1 selects [15:8] and the upper pin.
- R4: The bus is sampled at the edge that ends a read. The following cycle carries `host_ack` high for exactly one cycle, with `host_rdata` holding the sampled word and zero in each lane whose `host_be` bit is 0.
- R5: A write holds chip enable and write enable low, with the selected byte enables low, for PW_CYC cycles. PW_CYC is the largest rounded value among the pulse width, chip-enable-to-end, address-to-end, byte-enable-to-end and data-setup timings. Output enable stays high throughout. Address and data are valid from the first pulse cycle.
- R6: After the pulse, data stays driven for HD_CYC cycles with write enable high. Idle recovery cycles then bring the write cycle up to WC_CYC, and the acknowledge cycle follows.
- R7: The controller drives the data bus only in pulse and hold cycles, so the memory's read data reaches the bus undisturbed.
- R8: A write accepted after a read spends TA_CYC idle cycles (rounded output-release time) before the pulse. A write after a write starts the pulse at once.
- R9: A request is accepted only in IDLE. Host inputs that change while an access is in progress do not affect it.
- R10: A write changes only the selected lanes of the addressed word. A mask of 0 leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset; restarts the power-up wait |
| pwr_ready | output | 1 | High once the power-up wait has elapsed |
| host_req | input | 1 | Access request, sampled in IDLE |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | 2*LANE_W | Write data |
| host_be | input | 2 | Lane select: bit 0 low byte, bit 1 high byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 2*LANE_W | Read data, valid with `host_ack` after a read |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq | inout | 2*LANE_W | Bidirectional memory data bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |

## Verification
The assertions assume the host raises `host_req` only after `pwr_ready` and only while the controller is idle. They also assume the memory drives the bus only while chip and output enable are low and write enable is high. The stimulus keeps to these rules. It issues each request on the falling edge after the previous access has gone back to idle. It holds the request only in one case, where it deliberately scrambles the host inputs during a busy access and drops the request during the acknowledge cycle. The memory model in the bench drives only the selected lanes, and only during read phases. The one request made before power-up completes is withdrawn before `pwr_ready` rises.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WPULSE,
        ST_WHOLD,
        ST_WRECOV,
        ST_ACK
    } sram_state_e;

    // Whole clock cycles covering a nanosecond interval; zero stays zero.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        if (ns <= 0) return 0;
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwrup_gate.sv
module sram_pwrup_gate #(
    parameter int PWR_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int W = $clog2(PWR_CYC + 1);

    logic [W-1:0] elapsed_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                       elapsed_q <= '0;
        else if (elapsed_q != W'(PWR_CYC)) elapsed_q <= elapsed_q + 1'b1;
    end

    assign ready = (elapsed_q == W'(PWR_CYC));

    // R1: once open, the gate never closes again until reset
    assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

endmodule

// File: rtl/sram_span_timer.sv
module sram_span_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            left_q <= '0;
        else if (load)         left_q <= load_val;
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign done = (left_q == '0);

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    drive,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    capture,
    input  logic [LANES-1:0]        lane_en,
    output logic [LANES*LANE_W-1:0] rdata,
    inout  wire  [LANES*LANE_W-1:0] dq
);
    localparam int DW = LANES * LANE_W;

    logic [DW-1:0] lane_mask;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{lane_en[l]}};
    end

    assign dq = drive ? wdata : {DW{1'bz}};

    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (capture) rdata <= dq & lane_mask;
    end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W          = 18,
    parameter int LANE_W          = 8,
    parameter int CLK_NS          = 5,
    parameter int PWRUP_NS        = 100000,
    parameter int RD_CYCLE_NS     = 10,
    parameter int ADDR_ACCESS_NS  = 10,
    parameter int CE_ACCESS_NS    = 10,
    parameter int OE_ACCESS_NS    = 5,
    parameter int BE_ACCESS_NS    = 5,
    parameter int OE_RELEASE_NS   = 5,
    parameter int WR_CYCLE_NS     = 10,
    parameter int WE_PULSE_NS     = 7,
    parameter int CE_TO_WEND_NS   = 7,
    parameter int ADDR_TO_WEND_NS = 7,
    parameter int BE_TO_WEND_NS   = 7,
    parameter int DSETUP_NS       = 5,
    parameter int DHOLD_NS        = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic                  pwr_ready,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [2*LANE_W-1:0]   host_wdata,
    input  logic [1:0]            host_be,
    output logic                  host_ack,
    output logic [2*LANE_W-1:0]   host_rdata,
    output logic [ADDR_W-1:0]     sram_addr,
    inout  wire  [2*LANE_W-1:0]   sram_dq,
    output logic                  sram_ce_n,
    output logic                  sram_oe_n,
    output logic                  sram_we_n,
    output logic                  sram_ub_n,
    output logic                  sram_lb_n
);
    localparam int LANES = 2;
    localparam int DW    = LANES * LANE_W;

    localparam int RD_CYC = max2(1, max2(
        max2(ns_to_cycles(RD_CYCLE_NS, CLK_NS), ns_to_cycles(ADDR_ACCESS_NS, CLK_NS)),
        max2(max2(ns_to_cycles(CE_ACCESS_NS, CLK_NS), ns_to_cycles(OE_ACCESS_NS, CLK_NS)),
             ns_to_cycles(BE_ACCESS_NS, CLK_NS))));
    localparam int PW_CYC = max2(1, max2(
        max2(ns_to_cycles(WE_PULSE_NS, CLK_NS), ns_to_cycles(CE_TO_WEND_NS, CLK_NS)),
        max2(max2(ns_to_cycles(ADDR_TO_WEND_NS, CLK_NS), ns_to_cycles(BE_TO_WEND_NS, CLK_NS)),
             ns_to_cycles(DSETUP_NS, CLK_NS))));
    localparam int HD_CYC  = ns_to_cycles(DHOLD_NS, CLK_NS);
    localparam int WC_CYC  = ns_to_cycles(WR_CYCLE_NS, CLK_NS);
    localparam int REC_CYC = (WC_CYC > PW_CYC + HD_CYC) ? (WC_CYC - PW_CYC - HD_CYC) : 0;
    localparam int TA_CYC  = ns_to_cycles(OE_RELEASE_NS, CLK_NS);
    localparam int PWR_CYC = max2(1, ns_to_cycles(PWRUP_NS, CLK_NS));
    localparam int SPAN_MAX_CYC = max2(max2(RD_CYC, PW_CYC), max2(max2(HD_CYC, REC_CYC), TA_CYC));
    localparam int CW = $clog2(SPAN_MAX_CYC + 1) + 1;

    sram_state_e state_q, state_d;

    logic              accept;
    logic              tmr_load, tmr_done;
    logic [CW-1:0]     tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     wdata_q;
    logic [1:0]        be_q;
    logic [1:0]        lane_sel;
    logic              after_read_q;
    logic              drive_q;
    logic              capture;

    sram_pwrup_gate #(.PWR_CYC(PWR_CYC)) u_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (pwr_ready)
    );

    sram_span_timer #(.W(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign capture = (state_q == ST_READ) && tmr_done;

    sram_dq_port #(.LANE_W(LANE_W), .LANES(LANES)) u_dq (
        .clk     (clk),
        .rst_n   (rst_n),
        .drive   (drive_q),
        .wdata   (wdata_q),
        .capture (capture),
        .lane_en (be_q),
        .rdata   (host_rdata),
        .dq      (sram_dq)
    );

    assign accept   = (state_q == ST_IDLE) && host_req;
    assign lane_sel = (state_q == ST_IDLE) ? host_be : be_q;
    assign sram_addr = addr_q;

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q       <= '0;
            wdata_q      <= '0;
            be_q         <= '0;
            after_read_q <= 1'b0;
        end else if (accept) begin
            addr_q       <= host_addr;
            wdata_q      <= host_wdata;
            be_q         <= host_be;
            after_read_q <= !host_we;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWERUP: if (pwr_ready) state_d = ST_IDLE;
            ST_IDLE: begin
                if (host_req) begin
                    if (!host_we)                         state_d = ST_READ;
                    else if (after_read_q && TA_CYC > 0)  state_d = ST_TURN;
                    else                                  state_d = ST_WPULSE;
                end
            end
            ST_READ:  if (tmr_done) state_d = ST_ACK;
            ST_TURN:  if (tmr_done) state_d = ST_WPULSE;
            ST_WPULSE: begin
                if (tmr_done) begin
                    if (HD_CYC > 0)       state_d = ST_WHOLD;
                    else if (REC_CYC > 0) state_d = ST_WRECOV;
                    else                  state_d = ST_ACK;
                end
            end
            ST_WHOLD: begin
                if (tmr_done) begin
                    if (REC_CYC > 0) state_d = ST_WRECOV;
                    else             state_d = ST_ACK;
                end
            end
            ST_WRECOV: if (tmr_done) state_d = ST_ACK;
            ST_ACK:    state_d = ST_IDLE;
        endcase
    end

    // Phase timer loads on every state change
    always_comb begin
        tmr_load = (state_d != state_q);
        tmr_val  = '0;
        unique case (state_d)
            ST_READ:   tmr_val = CW'(RD_CYC - 1);
            ST_TURN:   tmr_val = CW'(max2(TA_CYC, 1) - 1);
            ST_WPULSE: tmr_val = CW'(PW_CYC - 1);
            ST_WHOLD:  tmr_val = CW'(max2(HD_CYC, 1) - 1);
            ST_WRECOV: tmr_val = CW'(max2(REC_CYC, 1) - 1);
            default:   tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_POWERUP;
        else        state_q <= state_d;
    end

    // Registered pin outputs, decoded from the state being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_ce_n <= 1'b1;
            sram_oe_n <= 1'b1;
            sram_we_n <= 1'b1;
            sram_ub_n <= 1'b1;
            sram_lb_n <= 1'b1;
            drive_q   <= 1'b0;
            host_ack  <= 1'b0;
        end else begin
            sram_ce_n <= !(state_d inside {ST_READ, ST_WPULSE});
            sram_oe_n <= (state_d != ST_READ);
            sram_we_n <= (state_d != ST_WPULSE);
            sram_ub_n <= !((state_d inside {ST_READ, ST_WPULSE}) && lane_sel[1]);
            sram_lb_n <= !((state_d inside {ST_READ, ST_WPULSE}) && lane_sel[0]);
            drive_q   <= (state_d inside {ST_WPULSE, ST_WHOLD});
            host_ack  <= (state_d == ST_ACK);
        end
    end

    // ---------------- assertions ----------------
    localparam int SW = $clog2(SPAN_MAX_CYC + 2) + 1;

    logic [SW-1:0] oe_low_cnt, we_low_cnt, oe_high_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_low_cnt  <= '0;
            we_low_cnt  <= '0;
            oe_high_cnt <= '1;
        end else begin
            if (!sram_oe_n) oe_low_cnt <= (oe_low_cnt == '1) ? oe_low_cnt : oe_low_cnt + 1'b1;
            else            oe_low_cnt <= '0;
            if (!sram_we_n) we_low_cnt <= (we_low_cnt == '1) ? we_low_cnt : we_low_cnt + 1'b1;
            else            we_low_cnt <= '0;
            if (sram_oe_n)  oe_high_cnt <= (oe_high_cnt == '1) ? oe_high_cnt : oe_high_cnt + 1'b1;
            else            oe_high_cnt <= '0;
        end
    end

    // R1: no memory access and no acknowledge before the power-up wait ends
    assert_no_access_unready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ready |-> (sram_ce_n && !host_ack));

    // R3: output enable stays low for the full read span
    assert_read_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (oe_low_cnt >= SW'(RD_CYC)));

    // R4: acknowledge is a single-cycle pulse
    assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R5: output enable is high whenever write enable is low
    assert_write_oe_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    // R5: write enable pulse lasts at least the write pulse span
    assert_we_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt >= SW'(PW_CYC)));

    // R7: the bus is never driven while the memory may be driving it
    assert_drive_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_q |-> sram_oe_n);

    // R8: write pulse starts only after the memory has released the bus
    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> (oe_high_cnt >= SW'(TA_CYC)));

endmodule

// File: tb/tb_async_sram_ctrl.sv
module tb_async_sram_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = 18;

    function automatic int up5(input int ns);
        return (ns <= 0) ? 0 : (ns + 4) / 5;
    endfunction

    // Expected phase lengths for a 5 ns clock with the default timings
    localparam int E_RD  = up5(10);
    localparam int E_PW  = up5(7);
    localparam int E_HD  = up5(0);
    localparam int E_WC  = up5(10);
    localparam int E_REC = (E_WC > E_PW + E_HD) ? E_WC - E_PW - E_HD : 0;
    localparam int E_TA  = up5(5);
    localparam int E_PWR = up5(100000);

    logic clk = 1'b0;
    logic rst_n;
    logic pwr_ready, host_req, host_we, host_ack;
    logic [AW-1:0] host_addr, sram_addr;
    logic [15:0] host_wdata, host_rdata;
    logic [1:0] host_be;
    wire  [15:0] sram_dq;
    logic sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n;

    always #2.5 clk = ~clk;

    async_sram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pwr_ready(pwr_ready),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_be(host_be), .host_ack(host_ack),
        .host_rdata(host_rdata), .sram_addr(sram_addr), .sram_dq(sram_dq),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n)
    );

    // ---------------- memory model (64 words, aliased) ----------------
    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 16'd773) ^ 16'hC3A5;
    endfunction

    logic [15:0] sram_mem [0:63];
    logic [15:0] shadow   [0:63];
    logic [15:0] rd_word;
    logic        rd_act;
    logic [15:0] wl_data;
    logic [1:0]  wl_be;
    logic [5:0]  wl_addr;
    logic        wl_pend;

    always_comb begin
        rd_act  = !sram_ce_n && !sram_oe_n && sram_we_n;
        rd_word = sram_mem[sram_addr[5:0]];
    end
    assign sram_dq[7:0]  = (rd_act && !sram_lb_n) ? rd_word[7:0]  : 8'bz;
    assign sram_dq[15:8] = (rd_act && !sram_ub_n) ? rd_word[15:8] : 8'bz;

    initial begin
        for (int i = 0; i < 64; i++) begin
            sram_mem[i] = init_word(i);
            shadow[i]   = init_word(i);
        end
        wl_pend = 1'b0;
    end

    always @(posedge clk) begin
        if (!sram_ce_n && !sram_we_n) begin
            wl_data <= sram_dq;
            wl_be   <= {!sram_ub_n, !sram_lb_n};
            wl_addr <= sram_addr[5:0];
            wl_pend <= 1'b1;
        end else if (wl_pend) begin
            if (wl_be[0]) sram_mem[wl_addr][7:0]  <= wl_data[7:0];
            if (wl_be[1]) sram_mem[wl_addr][15:8] <= wl_data[15:8];
            wl_pend <= 1'b0;
        end
    end

    // ---------------- reference model: expected per-cycle port values ----------------
    typedef struct packed {
        logic [4:0]    pins;   // ce_n, oe_n, we_n, ub_n, lb_n
        logic          ack;
        logic          chk_addr;
        logic [AW-1:0] addr;
        logic          chk_rd;
        logic [15:0]   rdata;
        logic          chk_dq;
        logic [15:0]   dq;
        logic [7:0]    rq;
        logic [7:0]    dq_rq;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   fails  = 0;
    int   edges  = 0;
    bit   last_rd = 1'b0;

    function automatic exp_t idle_e(input int rq);
        exp_t e;
        e = '0;
        e.pins = 5'b11111;
        e.rq = 8'(rq);
        return e;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Compare every clock, 1 ns after the rising edge
    initial begin
        wait (rst_n === 1'b1);
        forever begin
            exp_t e;
            logic [4:0] got;
            @(posedge clk);
            edges++;
            #1;
            if (expq.size() > 0) e = expq.pop_front();
            else                 e = idle_e((edges < E_PWR) ? 1 : 9);
            got = {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n};
            checks++;
            if (got !== e.pins || host_ack !== e.ack || (e.chk_addr && sram_addr !== e.addr)) begin
                fails++;
                $display("FAIL R%0d cycle %0d: pins=%b ack=%b addr=%h expected pins=%b ack=%b addr=%h",
                         e.rq, edges, got, host_ack, sram_addr, e.pins, e.ack, e.addr);
            end
            checks++;  // R1 power-up gate
            if (pwr_ready !== (edges >= E_PWR)) begin
                fails++;
                $display("FAIL R1 cycle %0d: pwr_ready=%b expected %b", edges, pwr_ready, edges >= E_PWR);
            end
            if (e.chk_rd) begin  // R4 read data
                checks++;
                if (host_rdata !== e.rdata) begin
                    fails++;
                    $display("FAIL R4 cycle %0d: rdata=%h expected %h", edges, host_rdata, e.rdata);
                end
            end
            if (e.chk_dq) begin  // R5 / R7 bus contents
                checks++;
                if (sram_dq !== e.dq) begin
                    fails++;
                    $display("FAIL R%0d cycle %0d: dq=%h expected %h", e.dq_rq, edges, sram_dq, e.dq);
                end
            end
            if (edges > 60000) begin
                fails++;
                $display("FAIL watchdog expired at cycle %0d: got running, expected finished", edges);
                finish_run();
            end
        end
    end

    // One host access; called on a falling edge while the controller is idle
    task automatic access(input bit w, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] m, input bit hold);
        exp_t e;
        logic [15:0] exp_rd;
        host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d; host_be = m;
        if (!w) begin
            exp_rd = shadow[a[5:0]] & {{8{m[1]}}, {8{m[0]}}};
            for (int i = 0; i < E_RD; i++) begin
                e = '0;
                e.pins = {3'b001, !m[1], !m[0]};            // R3
                e.chk_addr = 1'b1; e.addr = a; e.rq = 8'd3;
                if (m == 2'b11) begin                        // R7 bus carries memory data only
                    e.chk_dq = 1'b1; e.dq = shadow[a[5:0]]; e.dq_rq = 8'd7;
                end
                expq.push_back(e);
            end
            e = idle_e(4); e.ack = 1'b1; e.chk_rd = 1'b1; e.rdata = exp_rd;  // R4
            expq.push_back(e);
            last_rd = 1'b1;
        end else begin
            if (last_rd)
                for (int i = 0; i < E_TA; i++) expq.push_back(idle_e(8));  // R8
            for (int i = 0; i < E_PW; i++) begin
                e = '0;
                e.pins = {3'b010, !m[1], !m[0]};            // R5
                e.chk_addr = 1'b1; e.addr = a; e.rq = 8'd5;
                e.chk_dq = 1'b1; e.dq = d; e.dq_rq = 8'd5;
                expq.push_back(e);
            end
            for (int i = 0; i < E_HD; i++) begin
                e = idle_e(6); e.chk_dq = 1'b1; e.dq = d; e.dq_rq = 8'd6;   // R6
                expq.push_back(e);
            end
            for (int i = 0; i < E_REC; i++) expq.push_back(idle_e(6));
            e = idle_e(6); e.ack = 1'b1;                    // R6 ack right after the write cycle
            expq.push_back(e);
            if (m[0]) shadow[a[5:0]][7:0]  = d[7:0];         // R10 lane-masked update
            if (m[1]) shadow[a[5:0]][15:8] = d[15:8];
            last_rd = 1'b0;
        end
        expq.push_back(idle_e(9));
        @(posedge clk);
        @(negedge clk);
        if (hold) begin  // R9: scramble inputs while busy, keep req high until the ack cycle
            host_addr = ~a; host_wdata = ~d; host_we = !w; host_be = ~m;
            while (expq.size() > 1) @(negedge clk);
        end
        host_req = 1'b0;
        while (expq.size() != 0) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0;
        host_addr = '0; host_wdata = '0; host_be = 2'b00;
        repeat (4) @(negedge clk);
        checks++;  // R2 reset state
        if ({sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n} !== 5'b11111 ||
            host_ack !== 1'b0 || pwr_ready !== 1'b0) begin
            fails++;
            $display("FAIL R2: pins=%b ack=%b ready=%b expected 11111 0 0",
                     {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n}, host_ack, pwr_ready);
        end
        rst_n = 1'b1;

        // R1: request during the power-up wait is ignored (idle pins checked each cycle)
        repeat (50) @(negedge clk);
        host_req = 1'b1; host_addr = 18'h3; host_be = 2'b11;
        repeat (10) @(negedge clk);
        host_req = 1'b0;
        while (!pwr_ready) @(negedge clk);
        repeat (3) @(negedge clk);

        access(1'b0, 18'h00005, 16'h0000, 2'b11, 1'b0);  // R3 R4 read of initial content
        access(1'b1, 18'h00005, 16'h1234, 2'b11, 1'b0);  // R8 write after read
        access(1'b0, 18'h00005, 16'h0000, 2'b11, 1'b0);  // R10 readback
        access(1'b1, 18'h00009, 16'hABCD, 2'b01, 1'b0);  // R5 low lane only
        access(1'b1, 18'h00009, 16'h5678, 2'b10, 1'b0);  // R8 write after write, no gap
        access(1'b0, 18'h00009, 16'h0000, 2'b11, 1'b0);  // R10 merged lanes
        access(1'b0, 18'h00009, 16'h0000, 2'b01, 1'b0);  // R4 upper lane reads zero
        access(1'b0, 18'h00009, 16'h0000, 2'b10, 1'b0);  // R4 lower lane reads zero
        access(1'b0, 18'h20011, 16'h0000, 2'b11, 1'b1);  // R9 busy inputs ignored
        access(1'b1, 18'h20011, 16'hFFFF, 2'b00, 1'b1);  // R9 R10 empty mask
        access(1'b0, 18'h20011, 16'h0000, 2'b11, 1'b0);  // R10 word unchanged
        for (int k = 0; k < 12; k++) begin
            logic [AW-1:0] a;
            a = AW'((k * 37 + 11) % 64) | AW'(k << 12);
            access(1'b1, a, 16'(k * 4099 + 17), 2'(k % 4), 1'b0);
            access(1'b0, a, 16'h0000, 2'(3 - (k % 3)), 1'b0);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule